// File: doc/BRIEF.md
# Divided Local Countdown Timer

This block is the timer slice of a local interrupt unit. Software loads an initial count, picks a clock divide ratio and programs the timer entry, which holds a vector, a mask and a mode. The current count then falls by one on every divided tick. When it reaches zero the block raises an interrupt request that carries the entry's vector. In one-shot mode the count stops at zero. In periodic mode it reloads and keeps running.

The block also owns all six local vector entries, so it can apply the enable-driven masking. Clearing the enable bit masks every entry at once. An entry written while the block is disabled is stored already masked. Register access is a single-cycle write strobe plus a combinational read mux.

The interrupt request leaves on a valid/ready channel. Once `irq_valid` is high it stays high, and `irq_vector` stays stable, until a cycle in which `irq_ready` is high. Further expiries while the request waits are merged into the waiting request. A write to the initial count withdraws a waiting request.

Top module: `divided_local_timer`

## Requirements
- R1: After reset the initial count, current count and divide field read 0. The enable register reads 0x0FF, so the block is disabled. Every entry reads 0x0001_0000 (mask only). `irq_valid` is low.
- R2: Register selects are 0 initial count, 1 current count (read only), 2 divide field [3:0], 3 enable register [9:0] and 4..9 entries 0..5, where entry 0 is the timer. The divide exponent is ({d[3], d[1:0]} + 1) mod 8 and the ratio is 2 to that power. Code 4'b1011 divides by 1, 4'b0000 by 2 and 4'b1010 by 128.
- R3: While the count runs, it falls by exactly one on each divided tick and holds otherwise. Reads return its live value.
- R4: Writing the initial count loads it into the current count, restarts the divider from zero and withdraws any waiting request.
- R5: In one-shot mode (timer entry bit 17 = 0), expiry leaves the current count at 0, and it stays there.
- R6: In periodic mode (timer entry bit 17 = 1), expiry reloads the initial count on the same tick, and counting continues.
- R7: Expiry raises `irq_valid` with `irq_vector` = timer entry [7:0], but only if enable bit 8 is set and entry bit 16 (mask) is clear. The request holds with a stable vector until `irq_ready`.
- R8: An initial count of 0 starts no countdown and raises no request.
- R9: A write that clears enable bit 8 sets bit 16 in all six entries. An entry write while disabled is stored with bit 16 set.
- R10: Entry writes are filtered as follows. Entry 0 keeps bits 17, 16, 12 and 7:0. Entries 1–2 keep 16, 12 and 10:0. Entries 3–4 keep 16:12 and 10:0. Entry 5 keeps 16, 12 and 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Write register select |
| wr_data | input | 32 | Write data |
| rd_sel | input | 4 | Read register select |
| rd_data | output | 32 | Read data (combinational) |
| irq_valid | output | 1 | Interrupt request waiting |
| irq_ready | input | 1 | Controller accepts the request |
| irq_vector | output | 8 | Vector of the waiting request |

## Verification
A wrong divider state shows up within one divided period. It appears as the current count stepping on the wrong cycle, which is seen through the live read a single edge later. A wrong count or reload state appears as a missing, extra or mistimed vector on the request channel. The scoreboard catches it at the handshake, or when the run ends with the queue not empty. A masking fault shows up immediately on read-back of an entry, and on the request channel as a vector that should have been suppressed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W     = 32;
  localparam int SEL_W      = 4;
  localparam int NUM_LVT    = 6;
  localparam int MASK_BIT   = 16;
  localparam int PERIOD_BIT = 17;
  localparam int ENA_BIT    = 8;
  localparam int ENA_W      = 10;
  localparam int DIV_W      = 4;

  localparam logic [SEL_W-1:0] SEL_INIT = 4'd0;
  localparam logic [SEL_W-1:0] SEL_CUR  = 4'd1;
  localparam logic [SEL_W-1:0] SEL_DIV  = 4'd2;
  localparam logic [SEL_W-1:0] SEL_ENA  = 4'd3;
  localparam logic [SEL_W-1:0] SEL_LVT0 = 4'd4;

  // Writable bits of each local vector entry
  function automatic logic [DATA_W-1:0] lvt_keep(input int idx);
    logic [DATA_W-1:0] k;
    k = 32'h0001_10FF;
    if (idx == 0) k = k | 32'h0002_0000;
    if (idx == 1 || idx == 2) k = k | 32'h0000_0700;
    if (idx == 3 || idx == 4) k = k | 32'h0000_E700;
    return k;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int CODE_W = 4,
  parameter int EXP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int CNT_W = (1 << EXP_W) - 1;

  logic [EXP_W-1:0] exp_q;
  logic [CNT_W:0]   ratio;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    exp_q = {code[3], code[1:0]} + EXP_W'(1);
    ratio = (CNT_W+1)'(1) << exp_q;
    limit = CNT_W'(ratio - (CNT_W+1)'(1));
    tick  = !restart && (cnt >= limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart || tick) cnt <= '0;
    else                           cnt <= cnt + CNT_W'(1);
  end

  // R2: a restart always begins a fresh divided period
  a_r2_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] reload_val,
  input  logic          periodic,
  input  logic          tick,
  output logic [CW-1:0] cur,
  output logic          expire
);
  logic running;

  assign expire = running && tick && !load && (cur == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur     <= '0;
      running <= 1'b0;
    end else if (load) begin
      cur     <= load_val;
      running <= (load_val != '0);
    end else if (running && tick) begin
      if (cur == CW'(1)) begin
        cur     <= periodic ? reload_val : '0;
        running <= periodic && (reload_val != '0);
      end else begin
        cur <= cur - CW'(1);
      end
    end
  end

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cur));
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !load && cur > CW'(1)) |=> (cur == $past(cur) - CW'(1)));
  a_r5_oneshot_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !periodic) |=> (cur == '0 && !running));
  a_r8_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> (!running && cur == '0));
endmodule

// File: rtl/tmr_lvt_bank.sv
module tmr_lvt_bank
  import tmr_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      sw_en,
  input  logic                      mask_all,
  output logic [NUM_LVT*DATA_W-1:0] entries
);
  localparam logic [DATA_W-1:0] MASK_ONLY = DATA_W'(1) << MASK_BIT;

  logic [NUM_LVT-1:0] mask_bits;

  for (genvar g = 0; g < NUM_LVT; g++) begin : g_ent
    localparam logic [DATA_W-1:0] KEEP = lvt_keep(g);
    localparam logic [SEL_W-1:0]  MY_SEL = SEL_LVT0 + SEL_W'(g);
    logic [DATA_W-1:0] val;

    always_ff @(posedge clk) begin
      if (!rst_n)
        val <= MASK_ONLY;
      else if (mask_all)
        val <= val | MASK_ONLY;
      else if (wr_en && wr_sel == MY_SEL)
        val <= (wr_data | (sw_en ? '0 : MASK_ONLY)) & KEEP;
    end

    assign entries[g*DATA_W +: DATA_W] = val;
    assign mask_bits[g] = val[MASK_BIT];
  end

  // R9: while disabled, every entry carries its mask
  a_r9_off_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |-> (mask_bits == '1));
endmodule

// File: rtl/divided_local_timer.sv
module divided_local_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [7:0]        irq_vector
);
  logic [DATA_W-1:0]         init_q;
  logic [DIV_W-1:0]          div_q;
  logic [ENA_W-1:0]          ena_q;
  logic [NUM_LVT*DATA_W-1:0] lvt;
  logic [DATA_W-1:0]         timer_ent;
  logic [DATA_W-1:0]         cur;
  logic                      load, tick, expire, fire, mask_all, hold;

  assign load      = wr_en && wr_sel == SEL_INIT;
  assign mask_all  = wr_en && wr_sel == SEL_ENA && !wr_data[ENA_BIT];
  assign timer_ent = lvt[DATA_W-1:0];
  assign fire      = expire && ena_q[ENA_BIT] && !timer_ent[MASK_BIT];
  assign hold      = irq_valid && !irq_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q <= '0;
      div_q  <= '0;
      ena_q  <= ENA_W'(8'hFF);
    end else if (wr_en) begin
      if (wr_sel == SEL_INIT) init_q <= wr_data;
      if (wr_sel == SEL_DIV)  div_q  <= wr_data[DIV_W-1:0];
      if (wr_sel == SEL_ENA)  ena_q  <= wr_data[ENA_W-1:0];
    end
  end

  tmr_prescaler #(.CODE_W(DIV_W), .EXP_W(3)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart(load), .code(div_q), .tick(tick));

  tmr_countdown #(.CW(DATA_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(wr_data),
    .reload_val(init_q), .periodic(timer_ent[PERIOD_BIT]), .tick(tick),
    .cur(cur), .expire(expire));

  tmr_lvt_bank u_lvt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sw_en(ena_q[ENA_BIT]), .mask_all(mask_all),
    .entries(lvt));

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid <= fire || hold;
      if (fire && !hold) irq_vector <= timer_ent[7:0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_INIT: rd_data = init_q;
      SEL_CUR:  rd_data = cur;
      SEL_DIV:  rd_data = DATA_W'(div_q);
      SEL_ENA:  rd_data = DATA_W'(ena_q);
      default: begin
        for (int i = 0; i < NUM_LVT; i++)
          if (rd_sel == SEL_LVT0 + SEL_W'(i)) rd_data = lvt[i*DATA_W +: DATA_W];
      end
    endcase
  end

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready && !load) |=> (irq_valid && $stable(irq_vector)));
  a_r4_load_withdraws: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !irq_valid);
  a_r7_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_valid && (timer_ent[MASK_BIT] || !ena_q[ENA_BIT])) |=> !irq_valid);
endmodule

// File: tb/divided_local_timer_tb.sv
`timescale 1ns/100ps
module divided_local_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        irq_valid;
  logic        irq_ready = 1'b1;
  logic [7:0]  irq_vector;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  divided_local_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vector(irq_vector));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [31:0] v);
    rd_sel = s; #1; v = rd_data;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk_cur(input string req, input logic [31:0] e);
    logic [31:0] v;
    rd(4'd1, v); chk(req, v, e);
  endtask

  // Monitor: pop an expected vector on each accepted request
  always @(negedge clk) begin
    if (rst_n && irq_valid && irq_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7: actual unexpected vector 0x%02h expected none", irq_vector);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (irq_vector !== e) begin
          errors++;
          $display("FAIL R7: actual vector 0x%02h expected 0x%02h", irq_vector, e);
        end
      end
    end
  end

  task automatic drain(input string req);
    chk(req, 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        rd(4'd0, v); chk("R1 init", v, 0);
        rd(4'd1, v); chk("R1 cur", v, 0);
        rd(4'd2, v); chk("R1 div", v, 0);
        rd(4'd3, v); chk("R1 enable", v, 32'h0FF);
        for (int i = 0; i < 6; i++) begin
          rd(4'(4 + i), v); chk("R1 entry", v, 32'h0001_0000);
        end
        chk("R1 irq_valid", 32'(irq_valid), 0);

        // R10 write filters (enabled)
        wr(4'd3, 32'h1FF);
        wr(4'd4, 32'hFFFF_FFFF); rd(4'd4, v); chk("R10 entry0", v, 32'h0003_10FF);
        wr(4'd5, 32'hFFFF_FFFF); rd(4'd5, v); chk("R10 entry1", v, 32'h0001_17FF);
        wr(4'd7, 32'hFFFF_FFFF); rd(4'd7, v); chk("R10 entry3", v, 32'h0001_F7FF);
        wr(4'd9, 32'hFFFF_FFFF); rd(4'd9, v); chk("R10 entry5", v, 32'h0001_10FF);

        // R9 disable masks all; writes while off stored masked
        wr(4'd4, 32'h20); wr(4'd6, 32'h30);
        rd(4'd4, v); chk("R9 pre entry0", v, 32'h20);
        wr(4'd3, 32'h0FF);
        rd(4'd4, v); chk("R9 entry0 masked", v, 32'h0001_0020);
        rd(4'd6, v); chk("R9 entry2 masked", v, 32'h0001_0030);
        wr(4'd4, 32'h41); rd(4'd4, v); chk("R9 write while off", v, 32'h0001_0041);
        wr(4'd3, 32'h1FF);

        // R3 R5 R7 one-shot, divide by 1
        wr(4'd4, 32'h42); wr(4'd2, 32'hB);
        rd(4'd2, v); chk("R2 div readback", v, 32'hB);
        exp_q.push_back(8'h42);
        wr(4'd0, 5); chk_cur("R4 load", 5);
        for (int k = 1; k <= 5; k++) begin cyc(1); chk_cur("R3 step div1", 32'(5 - k)); end
        cyc(10); chk_cur("R5 stays zero", 0); drain("R5 one request");

        // R2 divide by 2
        wr(4'd2, 32'h0); exp_q.push_back(8'h42);
        wr(4'd0, 3);
        cyc(1); chk_cur("R2 div2 hold", 3);
        cyc(1); chk_cur("R2 div2 step", 2);
        cyc(1); chk_cur("R2 div2 hold2", 2);
        cyc(1); chk_cur("R2 div2 step2", 1);
        cyc(6); drain("R2 div2 expiry");

        // R2 divide by 128
        wr(4'd2, 32'hA); exp_q.push_back(8'h42);
        wr(4'd0, 2);
        cyc(127); chk_cur("R2 div128 hold", 2);
        cyc(1);   chk_cur("R2 div128 step", 1);
        cyc(132); drain("R2 div128 expiry");

        // R4 restart mid-count
        wr(4'd2, 32'hB); exp_q.push_back(8'h42);
        wr(4'd0, 5); cyc(2); chk_cur("R3 mid", 3);
        wr(4'd0, 4); chk_cur("R4 reload", 4);
        cyc(1); chk_cur("R4 continues", 3);
        cyc(8); drain("R4 single request");

        // R6 periodic
        wr(4'd4, 32'h0002_0055);
        for (int i = 0; i < 3; i++) exp_q.push_back(8'h55);
        wr(4'd0, 3);
        for (int k = 1; k <= 9; k++) begin
          cyc(1); chk_cur("R6 periodic count", 32'(3 - (k % 3)));
        end
        // R8 zero count stops everything
        wr(4'd0, 0); cyc(20);
        chk_cur("R8 zero cur", 0); chk("R8 no request", 32'(irq_valid), 0);
        drain("R6 three requests");

        // R7 masked entry: no request
        wr(4'd4, 32'h0001_0042); wr(4'd0, 2); cyc(6);
        chk("R7 masked no request", 32'(irq_valid), 0);

        // R7 back-pressure hold
        wr(4'd4, 32'h66); irq_ready = 1'b0;
        wr(4'd0, 2); cyc(6);
        chk("R7 held valid", 32'(irq_valid), 1);
        chk("R7 held vector", 32'(irq_vector), 32'h66);
        exp_q.push_back(8'h66); irq_ready = 1'b1; cyc(2);
        chk("R7 released", 32'(irq_valid), 0); drain("R7 back-pressure");

        // R4 load withdraws waiting request
        irq_ready = 1'b0; wr(4'd0, 1); cyc(3);
        chk("R4 waiting", 32'(irq_valid), 1);
        wr(4'd0, 0);
        chk("R4 withdrawn", 32'(irq_valid), 0);
        irq_ready = 1'b1; cyc(3); drain("R4 no leftover");
      end
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule